// File: doc/BRIEF.md
# Pipelined Converter Stage-Decision Corrector

This block sits behind the analog pipeline of an 8-bit converter. The pipeline has six redundant stages and a final 2-bit flash. Each redundant stage makes a three-level coarse decision. Because the pipeline works on several samples at once, the decisions for one sample arrive spread over several clocks. Stage 1 reports first, and each later stage reports one clock after the stage before it. The final flash reports in the same clock as stage 6.

The block delays each stage's decision by a different number of cycles, so that all decisions of one sample line up. It then adds them at weights that overlap by one bit. This overlap absorbs comparator errors in the earlier stages. The result is a corrected 8-bit code, issued in either offset-binary or two's-complement form.

A valid strobe travels with the stage-1 decision of each sample. It reappears as the output valid flag together with that sample's code.

Top module: `adc_dig_corr`

## Requirements
- R1: While reset is asserted, and directly after it, `codeValid` is 0 and `codeOut` is 0.
- R2: A sample presented with `sampleValid` high at clock edge n produces `codeValid` high after edge n+5, a latency of six edges. Back-to-back samples produce back-to-back valid outputs.
- R3: The stage-k decision of a sample (k = 1..6, carried in `stageCodes[2k-1:2k-2]`) is taken k-1 cycles after that sample's valid strobe. The flash code (`flashCode`) of the sample is taken 5 cycles after the strobe.
- R4: In offset-binary form the output equals the sum over k of decision_k × 2^(7-k), plus the flash code at weight 1.
- R5: A stage decision of value 3 is not a legal level. It is handled exactly as the value 2.
- R6: Suppose a residue chain with ideal gain 2 produces the decisions, and each stage comparator threshold (nominally ±1/4 of full scale) is displaced by less than 1/4 of full scale. The output then equals the ideal code floor(128 × (x + 1)) for an input x in [-1, 1).
- R7: `twosSel` is taken in the same cycle as the sample's flash code. When it is 0 the output is offset binary. When it is 1 the output is two's complement, which is the offset-binary code with bit 7 inverted.
- R8: `codeOut` keeps its last value in every cycle in which `codeValid` is 0.
- R9: `codeValid` is 0 after every edge whose corresponding input slot, six edges earlier, carried no valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Marks the stage-1 decision of a new sample |
| stageCodes | input | 12 | Six 2-bit stage decisions; stage k in bits [2k-1:2k-2] |
| flashCode | input | 2 | Final 2-bit flash decision |
| twosSel | input | 1 | 1 selects two's-complement output coding |
| codeValid | output | 1 | Corrected code is valid |
| codeOut | output | 8 | Corrected 8-bit code |

## Verification
The bench builds the block with its default of six redundant stages. This gives an 8-bit result and a staggered delay ladder that runs from five cycles for stage 1 down to none for stage 6.

With these values, an integer residue model can sweep inputs across the whole range, including both end codes. It can also displace every comparator threshold by up to about a fifth of full scale. The expected code is then compared with the ideal quantization of the input.

Streams that carry a different decision in every stage of every slot expose any misaligned delay. Gapped streams with changing format selection exercise the hold and valid-timing behaviour.

// File: rtl/adcfix_pkg.sv
package adcfix_pkg;

  // Strobes passed from the sequencing control to the datapath.
  typedef struct packed {
    logic load;   // aligned decisions form a valid sample this cycle
    logic twos;   // emit two's-complement coding for that sample
  } ctlStrobe_t;

  // Stage decisions carry three legal levels; the fourth encoding folds to the top level.
  function automatic logic [1:0] clampDecision(input logic [1:0] raw);
    return (raw == 2'd3) ? 2'd2 : raw;
  endfunction

endpackage

// File: rtl/adc_corr_ctrl.sv
module adc_corr_ctrl
  import adcfix_pkg::*;
#(
  parameter int NUM_STAGES = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  input  logic       twosSel,
  output ctlStrobe_t ctl,
  output logic       codeValid
);

  // One tap per pipeline cycle; tap NUM_STAGES-2 lines up with the last stage decision.
  logic [NUM_STAGES-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[NUM_STAGES-2:0], sampleValid};
    end
  end

  always_comb begin
    ctl.load = validPipe[NUM_STAGES-2];
    ctl.twos = twosSel;
  end

  assign codeValid = validPipe[NUM_STAGES-1];

  // R2: every load is reported as a valid output on the next edge
  p_load_to_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> codeValid);

  // R9: no valid output without a load one cycle earlier
  p_valid_origin_r9: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> $past(ctl.load));

endmodule

// File: rtl/adc_corr_dp.sv
module adc_corr_dp
  import adcfix_pkg::*;
#(
  parameter int NUM_STAGES = 6,
  parameter int OUT_BITS   = NUM_STAGES + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2*NUM_STAGES-1:0] stageCodes,
  input  logic [1:0]              flashCode,
  input  ctlStrobe_t              ctl,
  output logic [OUT_BITS-1:0]     codeOut
);

  localparam int SUM_BITS = OUT_BITS + 1;
  localparam logic [SUM_BITS-1:0] MAX_CODE = SUM_BITS'((1 << OUT_BITS) - 1);

  logic [1:0] aligned [NUM_STAGES];

  // Staggered alignment: stage gi+1 waits NUM_STAGES-1-gi cycles.
  for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_stage
    localparam int DLY = NUM_STAGES - 1 - gi;
    logic [1:0] legalCode;
    assign legalCode = clampDecision(stageCodes[2*gi +: 2]);

    if (DLY == 0) begin : g_direct
      assign aligned[gi] = legalCode;
    end else begin : g_delay
      logic [1:0] pipe [DLY];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int j = 0; j < DLY; j++) pipe[j] <= 2'd0;
        end else begin
          pipe[0] <= legalCode;
          for (int j = 1; j < DLY; j++) pipe[j] <= pipe[j-1];
        end
      end
      assign aligned[gi] = pipe[DLY-1];
    end
  end

  // Overlapping-weight accumulation: stage gi+1 weighs 2^(NUM_STAGES-gi).
  logic [SUM_BITS-1:0] sumWide;
  logic [OUT_BITS-1:0] satCode;

  always_comb begin
    sumWide = SUM_BITS'(flashCode);
    for (int i = 0; i < NUM_STAGES; i++) begin
      sumWide = sumWide + (SUM_BITS'(aligned[i]) << (NUM_STAGES - i));
    end
    satCode = (sumWide > MAX_CODE) ? MAX_CODE[OUT_BITS-1:0] : sumWide[OUT_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeOut <= '0;
    end else if (ctl.load) begin
      codeOut <= ctl.twos ? {~satCode[OUT_BITS-1], satCode[OUT_BITS-2:0]} : satCode;
    end
  end

  // Helpers for end-of-range checks
  logic allTop, allBottom;
  always_comb begin
    allTop    = (flashCode == 2'd3);
    allBottom = (flashCode == 2'd0);
    for (int i = 0; i < NUM_STAGES; i++) begin
      allTop    = allTop    && (aligned[i] == 2'd2);
      allBottom = allBottom && (aligned[i] == 2'd0);
    end
  end

  // R8: output register holds whenever no sample is loaded
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(codeOut));

  // R4: all-top decisions give full scale in offset binary
  p_full_scale_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.twos && allTop) |=> (codeOut == '1));

  // R4: all-bottom decisions give code zero in offset binary
  p_zero_scale_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.twos && allBottom) |=> (codeOut == '0));

  // R7: two's-complement zero-scale gives the most negative code
  p_twos_floor_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.twos && allBottom) |=> (codeOut == {1'b1, {(OUT_BITS-1){1'b0}}}));

endmodule

// File: rtl/adc_dig_corr.sv
module adc_dig_corr
  import adcfix_pkg::*;
#(
  parameter int NUM_STAGES = 6,
  localparam int OUT_BITS  = NUM_STAGES + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleValid,
  input  logic [2*NUM_STAGES-1:0] stageCodes,
  input  logic [1:0]              flashCode,
  input  logic                    twosSel,
  output logic                    codeValid,
  output logic [OUT_BITS-1:0]     codeOut
);

  ctlStrobe_t ctl;

  adc_corr_ctrl #(.NUM_STAGES(NUM_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .twosSel     (twosSel),
    .ctl         (ctl),
    .codeValid   (codeValid)
  );

  adc_corr_dp #(.NUM_STAGES(NUM_STAGES), .OUT_BITS(OUT_BITS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stageCodes (stageCodes),
    .flashCode  (flashCode),
    .ctl        (ctl),
    .codeOut    (codeOut)
  );

endmodule

// File: tb/sim_adc_dig_corr.sv
module sim_adc_dig_corr;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 6;
  localparam int MAXN = 64;
  localparam int FS = 1048576;  // full-scale unit of the residue model

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] stageCodes = '0;
  logic [1:0]  flashCode = '0;
  logic        twosSel = 1'b0;
  logic        codeValid;
  logic [7:0]  codeOut;

  int total = 0;
  int bad = 0;
  int lastCode = 0;
  int unsigned seed = 32'h1234_5678;

  logic [1:0] sd [MAXN][NS];
  logic [1:0] sf [MAXN];
  bit         sv [MAXN];
  bit         sfmt [MAXN];
  int         sexp [MAXN];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_dig_corr u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .stageCodes(stageCodes),
    .flashCode(flashCode), .twosSel(twosSel), .codeValid(codeValid), .codeOut(codeOut)
  );

  function automatic int unsigned nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Expected code from raw decisions per R4, R5, R7
  function automatic int sumExpect(input int s);
    int acc = int'(sf[s]);
    for (int k = 0; k < NS; k++) begin
      int d = (sd[s][k] == 2'd3) ? 2 : int'(sd[s][k]);
      acc += d * (1 << (NS - k));
    end
    return sfmt[s] ? (acc ^ 128) : acc;
  endfunction

  // Streams n slots; stage k of slot s is driven in cycle s+k, flash and format in cycle s+5.
  task automatic runStream(input string tag, input int n);
    for (int c = 0; c <= n + 6; c++) begin
      @(negedge clk);
      if (c >= 6 && c - 6 < n) begin
        int t = c - 6;
        if (sv[t]) begin
          check("R2 valid", int'(codeValid), 1);
          check(tag, int'(codeOut), sexp[t]);
          lastCode = sexp[t];
        end else begin
          check("R9 no-valid", int'(codeValid), 0);
          check("R8 hold", int'(codeOut), lastCode);
        end
      end
      begin
        logic [11:0] bus = '0;
        int fs = c - (NS - 1);
        for (int k = 0; k < NS; k++) begin
          int s = c - k;
          bus[2*k +: 2] = (s >= 0 && s < n) ? sd[s][k] : 2'd1;
        end
        stageCodes  = bus;
        sampleValid = (c < n) ? sv[c] : 1'b0;
        flashCode   = (fs >= 0 && fs < n) ? sf[fs] : 2'd0;
        twosSel     = (fs >= 0 && fs < n) ? sfmt[fs] : 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(codeValid), 0);
    check("R1 code in reset", int'(codeOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(codeValid), 0);
    check("R1 code after reset", int'(codeOut), 0);
    lastCode = 0;
  endtask

  // R3 and R4: different decisions in every stage of every slot expose misalignment
  task automatic t_weights();
    int n = 24;
    for (int s = 0; s < n; s++) begin
      for (int k = 0; k < NS; k++) sd[s][k] = 2'(nextRand() % 3);
      sf[s] = 2'(nextRand() % 4);
      if (s < NS) begin
        for (int k = 0; k < NS; k++) sd[s][k] = (k == s) ? 2'd2 : 2'd0;
        sf[s] = 2'd0;
      end
      sv[s] = 1'b1; sfmt[s] = 1'b0;
      sexp[s] = sumExpect(s);
    end
    runStream("R3/R4 weighted sum", n);
  endtask

  // R5: illegal level 3 folds to 2
  task automatic t_illegal();
    int n = 12;
    for (int s = 0; s < n; s++) begin
      for (int k = 0; k < NS; k++) sd[s][k] = 2'(nextRand() % 4);
      sd[s][s % NS] = 2'd3;
      if (s == 0) for (int k = 0; k < NS; k++) sd[s][k] = 2'd3;
      sf[s] = (s == 0) ? 2'd3 : 2'(nextRand() % 4);
      sv[s] = 1'b1; sfmt[s] = 1'b0;
      sexp[s] = sumExpect(s);
    end
    runStream("R5 illegal level", n);
  endtask

  // R6: ideal residue model with displaced thresholds; expectation from the input alone
  task automatic t_redundancy();
    int n = 48;
    for (int s = 0; s < n; s++) begin
      int x;
      int v;
      if (s == 0) x = -FS;
      else if (s == 1) x = FS - 1;
      else if (s == 2) x = 0;
      else x = int'(nextRand() % 2097152) - FS;
      v = x;
      for (int k = 0; k < NS; k++) begin
        int eHi = (s < 3) ? 0 : int'(nextRand() % 400001) - 200000;
        int eLo = (s < 3) ? 0 : int'(nextRand() % 400001) - 200000;
        int d = (v >= FS/4 + eHi) ? 2 : ((v >= -FS/4 + eLo) ? 1 : 0);
        sd[s][k] = 2'(d);
        v = 2 * v - (d - 1) * FS;
      end
      sf[s] = 2'((v + FS) >>> 19);
      sv[s] = 1'b1; sfmt[s] = 1'b0;
      sexp[s] = (x + FS) >>> 13;
    end
    runStream("R6 redundancy", n);
  endtask

  // R7: format alternates per slot
  task automatic t_format();
    int n = 16;
    for (int s = 0; s < n; s++) begin
      for (int k = 0; k < NS; k++) sd[s][k] = 2'(nextRand() % 3);
      if (s == 1) for (int k = 0; k < NS; k++) sd[s][k] = 2'd0;
      if (s == 3) for (int k = 0; k < NS; k++) sd[s][k] = 2'd2;
      sf[s] = (s == 1) ? 2'd0 : ((s == 3) ? 2'd3 : 2'(nextRand() % 4));
      sv[s] = 1'b1; sfmt[s] = s[0];
      sexp[s] = sumExpect(s);
    end
    runStream("R7 format", n);
  endtask

  // R2, R8, R9: sparse valid strobes with format changes on empty slots
  task automatic t_gaps();
    int n = 30;
    for (int s = 0; s < n; s++) begin
      for (int k = 0; k < NS; k++) sd[s][k] = 2'(nextRand() % 3);
      sf[s] = 2'(nextRand() % 4);
      sv[s] = (s % 3 == 0) || (s == 10) || (s == 11);
      sfmt[s] = (nextRand() % 2) == 1;
      sexp[s] = sumExpect(s);
    end
    runStream("R2 gapped data", n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_weights();
    t_illegal();
    t_redundancy();
    t_format();
    t_gaps();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule